// File: doc/BRIEF.md
# Dual-Rail Supply Handover Sequencer

This block runs from an always-on supply and decides which of two supply rails, high or low, feeds a processor core. Each rail reaches the core through a bank of parallel gate segments, shown here as active-high enable bits. A rail change is requested through a valid/ready handshake. Once the request is taken, the block stalls the core. It then opens every segment of both rails and holds them all open for a dead time. Next it closes the target rail's segments one by one, so that inrush current stays small. Only when the last segment has settled does it release the stall and go back to waiting.

The handshake follows the usual stream rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when the block is idle. While `req_ready` is low, the requester sees back-pressure, and a request that is held or dropped in that time has no effect. A request for the rail already in use is taken and completed at once, with no stall and no change to any segment. The dead time and the step interval come from configuration inputs and are captured on the accepting edge.

Top module: `rail_switch_seq`

## Requirements
- R1: After reset, every high-rail segment is on and every low-rail segment is off. Also after reset, `core_stall` and `busy` are 0, `req_ready` is 1, and `rail_hi` is 1.
- R2: No segment of the high rail is on in the same cycle as any segment of the low rail.
- R3: In the cycle after a rail-changing request is taken, `core_stall` and `busy` are 1, and both enable vectors still hold their previous values.
- R4: One cycle after the stall rises, every segment of both rails is off.
- R5: Both rails stay fully off for `cfg_dead`+1 cycles. Then bit 0 of the target rail's enable vector turns on.
- R6: After bit 0, one more segment of the target rail turns on every `cfg_step`+1 cycles, from the lowest index upward, until all are on.
- R7: `cfg_step`+1 cycles after the last segment turns on, `core_stall` and `busy` fall. In that same cycle `rail_hi` takes the new rail (1 = high, 0 = low) and `req_ready` returns to 1.
- R8: `req_ready` is the inverse of `busy`. A request offered while `req_ready` is low changes nothing.
- R9: A request whose `req_rail` equals `rail_hi` is taken. It raises no stall and changes no segment.
- R10: `cfg_dead` and `cfg_step` are used as they were on the accepting edge. Later changes to them do not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Rail-change request offered |
| req_rail | input | 1 | Requested rail: 1 high, 0 low |
| req_ready | output | 1 | Block can take a request (idle) |
| cfg_dead | input | DEAD_W | Dead time; both rails off for this value + 1 cycles |
| cfg_step | input | STEP_W | Segment spacing; one segment every this value + 1 cycles |
| core_stall | output | 1 | Holds the core while the supply changes |
| hi_en | output | SEGS | High-rail segment enables |
| lo_en | output | SEGS | Low-rail segment enables |
| busy | output | 1 | A handover is in progress |
| rail_hi | output | 1 | Rail currently in use: 1 high, 0 low |

## Verification
Counting from the accepting edge as edge 0, the stall is visible after edge 0. Both rails read off after edge 1. Target segment i turns on at edge 2 + D + i·(S+1), and the release comes at edge 2 + D + N·(S+1), where D and S are the captured configuration values and N is the segment count. The bench model turns that timeline into the expected value of every output after each edge. The outputs are sampled at the falling edge and compared against that expectation every cycle. Stimulus covers several dead-time and step settings, same-rail requests, requests offered while the block is busy, and configuration changes made in the middle of a handover.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CUT  = 2'd1,
    SQ_DEAD = 2'd2,
    SQ_RAMP = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rsw_timer.sv
module rsw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R5: a loaded count only moves downward, one step at a time
  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rsw_gate_bank.sv
module rsw_gate_bank #(
  parameter int   SEGS   = 8,
  parameter logic RST_ON = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            grow,
  output logic [SEGS-1:0] en,
  output logic            full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= RST_ON ? '1 : '0;
    else if (clr)   en <= '0;
    else if (grow)  en <= {en[SEGS-2:0], 1'b1};
  end

  assign full = &en;

  // R6: each growth step adds exactly one segment above those already on
  a_r6_one_more: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && grow && !full) |=> ($countones(en) == $past($countones(en)) + 1
                                 && (en & $past(en)) == $past(en)));
endmodule

// File: rtl/rail_switch_seq.sv
module rail_switch_seq
  import rsw_pkg::*;
#(
  parameter int SEGS   = 8,
  parameter int DEAD_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rail,
  output logic              req_ready,
  input  logic [DEAD_W-1:0] cfg_dead,
  input  logic [STEP_W-1:0] cfg_step,
  output logic              core_stall,
  output logic [SEGS-1:0]   hi_en,
  output logic [SEGS-1:0]   lo_en,
  output logic              busy,
  output logic              rail_hi
);
  localparam int CNT_W = (DEAD_W > STEP_W) ? DEAD_W : STEP_W;

  seq_state_t        state_q;
  logic              tgt_hi_q;
  logic [STEP_W-1:0] step_q;
  logic              stall_q;
  logic              rail_q;

  logic             accept, go_switch;
  logic             t_load, t_dec, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             clr_all, grow_tgt, release_now;
  logic             hi_full, lo_full, tgt_full;

  assign accept    = req_valid && (state_q == SQ_IDLE);
  assign go_switch = accept && (req_rail != rail_q);
  assign tgt_full  = tgt_hi_q ? hi_full : lo_full;

  always_comb begin
    t_load      = 1'b0;
    t_dec       = 1'b0;
    t_val       = CNT_W'(step_q);
    clr_all     = 1'b0;
    grow_tgt    = 1'b0;
    release_now = 1'b0;
    unique case (state_q)
      SQ_CUT: begin
        clr_all = 1'b1;
        t_load  = 1'b1;
        t_val   = CNT_W'(cfg_dead_q);
      end
      SQ_DEAD: begin
        if (t_zero) begin
          grow_tgt = 1'b1;
          t_load   = 1'b1;
        end else t_dec = 1'b1;
      end
      SQ_RAMP: begin
        if (!t_zero)       t_dec = 1'b1;
        else if (tgt_full) release_now = 1'b1;
        else begin
          grow_tgt = 1'b1;
          t_load   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  logic [DEAD_W-1:0] cfg_dead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      tgt_hi_q   <= 1'b1;
      step_q     <= '0;
      cfg_dead_q <= '0;
      stall_q    <= 1'b0;
      rail_q     <= 1'b1;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (go_switch) begin
          state_q    <= SQ_CUT;
          stall_q    <= 1'b1;
          tgt_hi_q   <= req_rail;
          step_q     <= cfg_step;
          cfg_dead_q <= cfg_dead;
        end
        SQ_CUT:  state_q <= SQ_DEAD;
        SQ_DEAD: if (t_zero) state_q <= SQ_RAMP;
        SQ_RAMP: if (release_now) begin
          state_q <= SQ_IDLE;
          stall_q <= 1'b0;
          rail_q  <= tgt_hi_q;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  rsw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .dec(t_dec), .zero(t_zero)
  );

  rsw_gate_bank #(.SEGS(SEGS), .RST_ON(1'b1)) u_hi_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .grow(grow_tgt && tgt_hi_q),
    .en(hi_en), .full(hi_full)
  );

  rsw_gate_bank #(.SEGS(SEGS), .RST_ON(1'b0)) u_lo_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .grow(grow_tgt && !tgt_hi_q),
    .en(lo_en), .full(lo_full)
  );

  assign core_stall = stall_q;
  assign busy       = (state_q != SQ_IDLE);
  assign req_ready  = (state_q == SQ_IDLE);
  assign rail_hi    = rail_q;

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((|hi_en) && (|lo_en)));

  a_r3_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stall) |-> ($stable(hi_en) && $stable(lo_en)));

  a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stall) |=> (hi_en == '0 && lo_en == '0));

  a_r7_full_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_stall) |-> (rail_hi ? (&hi_en && lo_en == '0) : (&lo_en && hi_en == '0)));

  a_r9_same_rail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_rail == rail_hi) |=> (!core_stall && $stable(hi_en) && $stable(lo_en)));
endmodule

// File: tb/rail_switch_seq_bench.sv
module rail_switch_seq_bench;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rail = 1'b0;
  logic [7:0] cfg_dead = '0;
  logic [3:0] cfg_step = '0;
  logic req_ready, core_stall, busy, rail_hi;
  logic [N-1:0] hi_en, lo_en;

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  int  m_e = -1;
  int  m_d = 0, m_s = 0;
  bit  m_hi = 1'b1;

  always #4 clk = ~clk;

  rail_switch_seq #(.SEGS(N), .DEAD_W(8), .STEP_W(4)) u_rail_switch_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rail(req_rail),
    .req_ready(req_ready), .cfg_dead(cfg_dead), .cfg_step(cfg_step),
    .core_stall(core_stall), .hi_en(hi_en), .lo_en(lo_en),
    .busy(busy), .rail_hi(rail_hi)
  );

  function automatic int rel_edge(int d, int s);
    return 2 + d + N * (s + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_e  <= -1;
      m_hi <= 1'b1;
    end else if (m_e < 0) begin
      if (req_valid && req_rail != m_hi) begin
        m_e <= 0; m_d <= int'(cfg_dead); m_s <= int'(cfg_step);
      end
    end else if (m_e + 1 == rel_edge(m_d, m_s)) begin
      m_e  <= -1;
      m_hi <= ~m_hi;
    end else m_e <= m_e + 1;
  end

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] old_v, tgt_v, all_v;
      int cnt;
      cycles++;
      all_v = '1;
      if (m_e < 0) begin
        chk("R7/R8 stall", N'(core_stall), '0);
        chk("R8 busy", N'(busy), '0);
        chk("R8 ready", N'(req_ready), N'(1));
        chk("R7/R9 rail_hi", N'(rail_hi), N'(m_hi));
        chk("R2/R9 hi_en", hi_en, m_hi ? all_v : '0);
        chk("R2/R9 lo_en", lo_en, m_hi ? '0 : all_v);
      end else begin
        cnt = (m_e < 2 + m_d) ? 0 : (m_e - 2 - m_d) / (m_s + 1) + 1;
        if (cnt > N) cnt = N;
        tgt_v = N'((64'd1 << cnt) - 1);
        old_v = (m_e == 0) ? all_v : '0;
        chk("R3/R7 stall", N'(core_stall), N'(1));
        chk("R8 busy", N'(busy), N'(1));
        chk("R8 ready", N'(req_ready), '0);
        chk("R7 rail_hi", N'(rail_hi), N'(m_hi));
        chk("R4/R5/R6/R10 hi_en", hi_en, m_hi ? old_v : tgt_v);
        chk("R4/R5/R6/R10 lo_en", lo_en, m_hi ? tgt_v : old_v);
      end
    end
  end

  task automatic offer(bit rail, int d, int s);
    @(negedge clk);
    req_valid = 1'b1; req_rail = rail;
    cfg_dead = 8'(d); cfg_step = 4'(s);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 hi_en", hi_en, '1);
        chk("R1 lo_en", lo_en, '0);
        chk("R1 stall", N'(core_stall), '0);
        chk("R1 rail_hi", N'(rail_hi), N'(1));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        offer(1'b1, 4, 1);            // R9: same rail
        repeat (4) @(negedge clk);
        offer(1'b0, 3, 0); wait_idle();
        offer(1'b1, 0, 2);            // R10: change cfg mid-run, R8: busy offers
        repeat (3) @(negedge clk);
        cfg_dead = 8'd9; cfg_step = 4'd7;
        req_valid = 1'b1; req_rail = 1'b0;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        offer(1'b0, 5, 1); wait_idle();
        offer(1'b0, 2, 2);            // R9: low while low
        repeat (4) @(negedge clk);
        offer(1'b1, 0, 0); wait_idle();
        offer(1'b0, 17, 3); wait_idle();
      end
      begin
        while (wd < 20000) begin @(negedge clk); wd++; end
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule